// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Loader

This block keeps the two thresholds that a FIFO's partial-status flag logic compares against. The thresholds are held in four `WORD_W`-bit registers. The empty-side threshold is split into a low and a high word, and so is the full-side threshold. There is no address bus. A single active-low configuration select reaches the registers in a fixed, wrapping order, one register per access. Writes happen on the write clock and readback happens on the read clock. Each clock domain keeps its own position in that order.

While reset is applied, the block samples the configuration select. If the select is low, configuration access is enabled until the next reset. If it is high, the select is ignored and the block only passes writes through. While access is enabled and the select is low, the block holds the FIFO's own write strobe off, so configuration data never enters the FIFO.

The empty-side threshold is formed as {empty-high, empty-low}. The full-side threshold is formed as {full-high, full-low}. Both are cut to `PTR_W` bits (keeping the least significant bits) and driven straight to the flag comparators.

Top module: `ofs_load_seq`

## Requirements
- R1: Reset (rst_n low across at least one edge of each clock) sets empty-low and full-low to 7 and both high words to 0. It therefore sets ae_thresh = af_thresh = 7 and rd_data = 0, and puts both sequence positions at empty-low.
- R2: If cfg_sel_n is high while reset is applied, configuration access stays off until the next reset. In that state cfg_sel_n has no effect: the thresholds keep their reset values, rd_data does not change, and fifo_wr_n equals wr_req_n.
- R3: In configuration mode, each wr_clk rising edge with cfg_sel_n = 0 and wr_req_n = 0 stores wr_data into the register at the write position. It then advances the position through the order empty-low (0), empty-high (1), full-low (2), full-high (3). The access after full-high goes back to empty-low.
- R4: With cfg_sel_n = 1 and wr_req_n = 0, fifo_wr_n is 0 (a FIFO write) and no register changes. With wr_req_n = 1, no register changes whatever cfg_sel_n is.
- R5: In configuration mode, fifo_wr_n is 1 whenever cfg_sel_n is 0.
- R6: Raising cfg_sel_n does not reset either position. The next access continues at the register after the last one accessed.
- R7: In configuration mode, each rd_clk rising edge with cfg_sel_n = 0 and rd_req_n = 0 loads the register at the read position into rd_data and advances the read position in the same wrapping order as R3.
- R8: On rd_clk edges without a readback, rd_data holds its value.
- R9: ae_thresh is {empty-high, empty-low} and af_thresh is {full-high, full-low}, each cut to its lowest PTR_W bits.
- R10: The write and read positions advance independently. Writes do not move the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| cfg_sel_n | input | 1 | Active-low configuration select; sampled during reset to enable access |
| wr_req_n | input | 1 | Active-low write request |
| wr_data | input | WORD_W | Data written to the next threshold register |
| rd_req_n | input | 1 | Active-low read request |
| rd_data | output | WORD_W | Registered readback of threshold registers |
| fifo_wr_n | output | 1 | Write strobe passed on to the FIFO, active low |
| ae_thresh | output | PTR_W | Almost-empty threshold for the flag logic |
| af_thresh | output | PTR_W | Almost-full threshold for the flag logic |

## Verification
The bench writes past the fourth register to prove the wrap. A design that restarted at empty-low after the select is released, or that never wrapped, would put values into the wrong word, and the table's expected thresholds would disagree. Mid-sequence releases on both the write and read sides catch a position that is cleared when the select goes high. Readback after writes catches a read position that follows the write side. One vector writes a high word wide enough that its top bit lies beyond PTR_W, so a design that fails to truncate, or that concatenates the words in the wrong order, shows a wrong threshold. A reset with the select held high checks that configuration writes still reach the FIFO and leave the thresholds untouched in that mode.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  localparam int unsigned SLOTS  = 4;
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  typedef enum logic [SLOT_W-1:0] {
    SLOT_AE_LO = 2'd0,
    SLOT_AE_HI = 2'd1,
    SLOT_AF_LO = 2'd2,
    SLOT_AF_HI = 2'd3
  } slot_e;

  // Reset value for each slot: low words start at 7, high words at 0
  function automatic int unsigned slot_default(input int unsigned idx);
    if (idx == int'(SLOT_AE_LO) || idx == int'(SLOT_AF_LO)) return 7;
    return 0;
  endfunction

endpackage

// File: rtl/ofs_mode_latch.sv
module ofs_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  output logic prog_en
);
  // Sampled on every clock edge while reset is held; frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) prog_en <= ~sel_n;
  end
endmodule

// File: rtl/ofs_slot_ctr.sv
module ofs_slot_ctr #(
  parameter int unsigned SLOTS  = 4,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [SLOT_W-1:0] pos
);
  logic [SLOT_W-1:0] nxt;

  generate
    if ((1 << SLOT_W) == SLOTS) begin : g_pow2
      assign nxt = pos + 1'b1;
    end else begin : g_cmp
      assign nxt = (pos == SLOT_W'(SLOTS - 1)) ? '0 : pos + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)    pos <= '0;
    else if (step) pos <= nxt;
  end
endmodule

// File: rtl/ofs_reg_bank.sv
module ofs_reg_bank
  import ofs_pkg::*;
#(
  parameter int unsigned WORD_W = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [SLOT_W-1:0]             pos,
  input  logic [WORD_W-1:0]             din,
  output logic [SLOTS-1:0][WORD_W-1:0]  regs_o
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_o[i] <= WORD_W'(slot_default(i));
      else if (we && pos == SLOT_W'(i))
        regs_o[i] <= din;
    end
  end
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
  import ofs_pkg::*;
#(
  parameter int unsigned WORD_W = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd,
  input  logic [SLOT_W-1:0]             pos,
  input  logic [SLOTS-1:0][WORD_W-1:0]  regs_i,
  output logic [WORD_W-1:0]             dout
);
  always_ff @(posedge clk) begin
    if (!rst_n)  dout <= '0;
    else if (rd) dout <= regs_i[pos];
  end
endmodule

// File: rtl/ofs_load_seq.sv
module ofs_load_seq
  import ofs_pkg::*;
#(
  parameter int unsigned WORD_W = 9,
  parameter int unsigned PTR_W  = 17
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              cfg_sel_n,
  input  logic              wr_req_n,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_req_n,
  output logic [WORD_W-1:0] rd_data,
  output logic              fifo_wr_n,
  output logic [PTR_W-1:0]  ae_thresh,
  output logic [PTR_W-1:0]  af_thresh
);
  localparam int unsigned PAIR_W = 2 * WORD_W;

  logic                         prog_w, prog_r;
  logic                         cfg_wr, cfg_rd;
  logic [SLOT_W-1:0]            wr_pos, rd_pos;
  logic [SLOTS-1:0][WORD_W-1:0] regs;
  logic [PAIR_W-1:0]            ae_pair, af_pair;

  // Each clock domain records for itself whether configuration access is on
  ofs_mode_latch u_mode_w (.clk(wr_clk), .rst_n(rst_n), .sel_n(cfg_sel_n), .prog_en(prog_w));
  ofs_mode_latch u_mode_r (.clk(rd_clk), .rst_n(rst_n), .sel_n(cfg_sel_n), .prog_en(prog_r));

  assign cfg_wr    = prog_w & ~cfg_sel_n & ~wr_req_n;
  assign cfg_rd    = prog_r & ~cfg_sel_n & ~rd_req_n;
  assign fifo_wr_n = wr_req_n | (prog_w & ~cfg_sel_n);

  ofs_slot_ctr #(.SLOTS(SLOTS)) u_wr_pos (
    .clk(wr_clk), .rst_n(rst_n), .step(cfg_wr), .pos(wr_pos)
  );

  ofs_slot_ctr #(.SLOTS(SLOTS)) u_rd_pos (
    .clk(rd_clk), .rst_n(rst_n), .step(cfg_rd), .pos(rd_pos)
  );

  ofs_reg_bank #(.WORD_W(WORD_W)) u_bank (
    .clk(wr_clk), .rst_n(rst_n), .we(cfg_wr), .pos(wr_pos),
    .din(wr_data), .regs_o(regs)
  );

  ofs_readback #(.WORD_W(WORD_W)) u_rdbk (
    .clk(rd_clk), .rst_n(rst_n), .rd(cfg_rd), .pos(rd_pos),
    .regs_i(regs), .dout(rd_data)
  );

  // Threshold pairs, sized to the FIFO pointer width (R9)
  assign ae_pair   = {regs[SLOT_AE_HI], regs[SLOT_AE_LO]};
  assign af_pair   = {regs[SLOT_AF_HI], regs[SLOT_AF_LO]};
  assign ae_thresh = PTR_W'(ae_pair);
  assign af_thresh = PTR_W'(af_pair);
endmodule

// File: rtl/ofs_load_seq_chk.sv
module ofs_load_seq_chk
  import ofs_pkg::*;
#(
  parameter int unsigned WORD_W = 9,
  parameter int unsigned PTR_W  = 17
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              cfg_sel_n,
  input logic              wr_req_n,
  input logic [WORD_W-1:0] wr_data,
  input logic              rd_req_n,
  input logic [WORD_W-1:0] rd_data,
  input logic              fifo_wr_n,
  input logic [PTR_W-1:0]  ae_thresh,
  input logic [PTR_W-1:0]  af_thresh,
  input logic [SLOT_W-1:0] wr_pos,
  input logic [SLOT_W-1:0] rd_pos,
  input logic              prog_w,
  input logic              prog_r
);
  logic do_wr, do_rd;
  assign do_wr = prog_w && !cfg_sel_n && !wr_req_n;
  assign do_rd = prog_r && !cfg_sel_n && !rd_req_n;

  assert_wr_step_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    do_wr |=> wr_pos == SLOT_W'((int'($past(wr_pos)) + 1) % SLOTS));

  assert_first_slot_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (do_wr && wr_pos == SLOT_W'(0)) |=> ae_thresh[WORD_W-1:0] == $past(wr_data));

  assert_wr_hold_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !do_wr |=> $stable(wr_pos));

  assert_gate_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (prog_w && !cfg_sel_n) |-> fifo_wr_n);

  assert_off_stable_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !prog_w |=> ($stable(ae_thresh) && $stable(af_thresh)));

  assert_rd_step_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    do_rd |=> rd_pos == SLOT_W'((int'($past(rd_pos)) + 1) % SLOTS));

  assert_rd_hold_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !do_rd |=> $stable(rd_pos));

  assert_rd_quiet_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !do_rd |=> $stable(rd_data));
endmodule

bind ofs_load_seq ofs_load_seq_chk #(.WORD_W(WORD_W), .PTR_W(PTR_W)) chk_i (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .cfg_sel_n(cfg_sel_n),
  .wr_req_n(wr_req_n), .wr_data(wr_data), .rd_req_n(rd_req_n),
  .rd_data(rd_data), .fifo_wr_n(fifo_wr_n), .ae_thresh(ae_thresh),
  .af_thresh(af_thresh), .wr_pos(wr_pos), .rd_pos(rd_pos),
  .prog_w(prog_w), .prog_r(prog_r)
);

// File: tb/ofs_load_seq_tb_top.sv
`timescale 1ns/100ps
module ofs_load_seq_tb_top;
  localparam int unsigned WORD_W = 9;
  localparam int unsigned PTR_W  = 17;
  localparam int unsigned NVEC   = 10;
  localparam int unsigned VEC_W  = 2 + WORD_W + 2 * PTR_W + 1;

  // {sel_n, req_n, data, expected ae, expected af, expected fifo_wr_n}
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 9'h005, 17'h00005, 17'h00007, 1'b1},
    {1'b0, 1'b0, 9'h001, 17'h00205, 17'h00007, 1'b1},
    {1'b1, 1'b0, 9'h0AA, 17'h00205, 17'h00007, 1'b0},
    {1'b0, 1'b1, 9'h0FF, 17'h00205, 17'h00007, 1'b1},
    {1'b0, 1'b0, 9'h010, 17'h00205, 17'h00010, 1'b1},
    {1'b1, 1'b1, 9'h033, 17'h00205, 17'h00010, 1'b1},
    {1'b0, 1'b0, 9'h1FF, 17'h00205, 17'h1FE10, 1'b1},
    {1'b0, 1'b0, 9'h00C, 17'h0020C, 17'h1FE10, 1'b1},
    {1'b0, 1'b0, 9'h100, 17'h0000C, 17'h1FE10, 1'b1},
    {1'b1, 1'b0, 9'h044, 17'h0000C, 17'h1FE10, 1'b0}
  };

  logic              wr_clk = 1'b0;
  logic              rd_clk = 1'b0;
  logic              rst_n;
  logic              cfg_sel_n;
  logic              wr_req_n;
  logic [WORD_W-1:0] wr_data;
  logic              rd_req_n;
  logic [WORD_W-1:0] rd_data;
  logic              fifo_wr_n;
  logic [PTR_W-1:0]  ae_thresh;
  logic [PTR_W-1:0]  af_thresh;

  int  total = 0;
  int  fails = 0;
  bit  done  = 0;

  always #2.5 wr_clk = ~wr_clk;
  initial begin
    #1.2;
    forever #2.5 rd_clk = ~rd_clk;
  end

  ofs_load_seq #(.WORD_W(WORD_W), .PTR_W(PTR_W)) dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .cfg_sel_n(cfg_sel_n),
    .wr_req_n(wr_req_n), .wr_data(wr_data), .rd_req_n(rd_req_n),
    .rd_data(rd_data), .fifo_wr_n(fifo_wr_n), .ae_thresh(ae_thresh),
    .af_thresh(af_thresh)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic sel);
    rst_n = 1'b0; cfg_sel_n = sel; wr_req_n = 1'b1; rd_req_n = 1'b1; wr_data = '0;
    repeat (4) @(posedge wr_clk);
    #1 rst_n = 1'b1;
    @(posedge wr_clk);
    #1 cfg_sel_n = 1'b1;
  endtask

  task automatic wcyc(input logic s, input logic r, input logic [WORD_W-1:0] d,
                      input logic exp_fw, input string tag);
    cfg_sel_n = s; wr_req_n = r; wr_data = d;
    #1 check(tag, 32'(fifo_wr_n), 32'(exp_fw));
    @(posedge wr_clk);
    #1 wr_req_n = 1'b1; cfg_sel_n = 1'b1;
  endtask

  task automatic rcyc(input logic s, input logic r);
    cfg_sel_n = s; rd_req_n = r; wr_req_n = 1'b1;
    @(posedge rd_clk);
    #1 rd_req_n = 1'b1; cfg_sel_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge wr_clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    // R1 reset state
    check("R1 ae reset", 32'(ae_thresh), 32'd7);
    check("R1 af reset", 32'(af_thresh), 32'd7);
    check("R1 rd_data reset", 32'(rd_data), 32'd0);

    // R3 R4 R5 R6 R9 table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [VEC_W-1:0] v;
      v = VECS[i];
      wcyc(v[VEC_W-1], v[VEC_W-2], v[VEC_W-3 -: WORD_W], v[0], "R4 R5 fifo_wr_n");
      check("R3 R9 ae_thresh", 32'(ae_thresh), 32'(v[2*PTR_W:PTR_W+1]));
      check("R3 R9 af_thresh", 32'(af_thresh), 32'(v[PTR_W:1]));
    end

    // R10 read side still starts at empty-low; R7 order
    rcyc(1'b0, 1'b0); check("R7 R10 read slot0", 32'(rd_data), 32'h00C);
    rcyc(1'b0, 1'b0); check("R7 read slot1", 32'(rd_data), 32'h100);
    rcyc(1'b0, 1'b1); check("R8 no request hold", 32'(rd_data), 32'h100);
    rcyc(1'b1, 1'b0); check("R8 select high hold", 32'(rd_data), 32'h100);
    rcyc(1'b0, 1'b0); check("R6 read continues slot2", 32'(rd_data), 32'h010);
    rcyc(1'b0, 1'b0); check("R7 read slot3", 32'(rd_data), 32'h1FF);
    rcyc(1'b0, 1'b0); check("R7 read wraps", 32'(rd_data), 32'h00C);

    // R6 write side continues at full-low after six loads
    wcyc(1'b0, 1'b0, 9'h003, 1'b1, "R5 gate");
    check("R6 write continues", 32'(af_thresh), 32'h1FE03);
    check("R6 ae untouched", 32'(ae_thresh), 32'h0000C);

    // R2 access disabled when select high during reset
    do_reset(1'b1);
    check("R1 ae reset 2", 32'(ae_thresh), 32'd7);
    wcyc(1'b0, 1'b0, 9'h055, 1'b0, "R2 write passes to fifo");
    check("R2 ae unchanged", 32'(ae_thresh), 32'd7);
    check("R2 af unchanged", 32'(af_thresh), 32'd7);
    rcyc(1'b0, 1'b0); check("R2 readback off", 32'(rd_data), 32'd0);

    // R1 reset restores defaults after programming
    do_reset(1'b0);
    wcyc(1'b0, 1'b0, 9'h0E1, 1'b1, "R5 gate after reset");
    check("R1 R3 first load after reset", 32'(ae_thresh), 32'h000E1);
    check("R1 af default", 32'(af_thresh), 32'd7);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule